// File: doc/BRIEF.md
# Debug Single-Step Trace Sequencer

This controller sits inside a processor's debug engine and carries out a host Trace request while the core is halted in debug mode. It lets exactly one instruction run and then brings the core back into debug mode with its state arranged for the next host command. It drives the core through a small set of strobes: stack pop and push requests, each with an acknowledge and a 16-bit return-address path; a one-cycle run pulse with the address to execute; an instruction-pointer load port; set and clear pulses for the interrupt global enable; and stall, fetch-inhibit and halt lines. It reports a 2-bit debug status to the host.

A step always goes through the same stages. The sequencer first marks itself busy. It pops the return address, and it re-arms the interrupt enable only if that enable was on when debug mode was entered. It releases the core for one instruction. When the core reports that instruction complete, it stalls the core and inhibits the next fetch. It then pushes the saved address back, loads the debug vector into the instruction pointer, clears the interrupt enable, halts the core and reports idle. The enable value is sampled once, at debug entry, and is kept for every later step.

Top module: `trace_step_seq`

## Requirements
- R1: While rst_ni is low, and after it rises, status_o is 00 (not in debug) and every output strobe to the core is 0: pop_req_o, push_req_o, exec_go_o, ip_load_o, ige_set_o, ige_clr_o, stall_o, fetch_block_o and halt_o.
- R2: dbg_enter_i, sampled while status_o is 00, moves status_o to 01 (debug idle) with halt_o at 1 and records cpu_ige_i as the saved enable. dbg_enter_i at any other time leaves the saved enable unchanged.
- R3: A trace_i strobe sampled while status_o is 01 sets status_o to 10 (busy) on the next cycle. No other strobe to the core is active in that cycle.
- R4: A trace_i strobe sampled while status_o is 00 or 10 is ignored: the status stays as it was, or the running step goes on unchanged.
- R5: In the cycle after the busy cycle, pop_req_o is 1 for exactly one cycle. The sequencer then waits, however long it takes, for pop_ack_i, and captures pop_data_i in the cycle in which pop_ack_i is 1.
- R6: In the cycle after the pop acknowledge, ige_set_o pulses for one cycle if the saved enable is 1, and stays 0 if it is 0.
- R7: In the next cycle, exec_go_o is 1 for one cycle with exec_addr_o equal to the popped address, and halt_o is 0 from this cycle until the halt stage.
- R8: In the cycle in which instr_done_i is seen during the execute stage, stall_o and fetch_block_o both go to 1. They stay at 1 up to and including the halt stage. The execute stage has no time limit.
- R9: In the cycle after completion, push_req_o is 1 for exactly one cycle with push_data_o equal to the captured address, whatever pop_data_i does afterwards. The sequencer then waits for push_ack_i.
- R10: In the cycle after the push acknowledge, ip_load_o is 1 for one cycle with ip_value_o equal to 8010h.
- R11: In the next cycle, ige_clr_o pulses for one cycle. This is followed by one halt cycle (halt_o 1, status_o still 10), after which status_o returns to 01.
- R12: At most one of pop_req_o, ige_set_o, exec_go_o, push_req_o, ip_load_o and ige_clr_o is 1 in any cycle, and they occur in that order within a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_enter_i | input | 1 | Core has entered debug mode |
| cpu_ige_i | input | 1 | Live interrupt global enable of the core |
| trace_i | input | 1 | Host Trace command strobe |
| pop_req_o | output | 1 | One-cycle stack pop request |
| pop_ack_i | input | 1 | Pop acknowledge, qualifies pop_data_i |
| pop_data_i | input | 16 | Popped return address |
| ige_set_o | output | 1 | Set the interrupt global enable |
| ige_clr_o | output | 1 | Clear the interrupt global enable |
| exec_go_o | output | 1 | Run one instruction from exec_addr_o |
| exec_addr_o | output | 16 | Address of the instruction to run |
| instr_done_i | input | 1 | Stepped instruction has completed |
| stall_o | output | 1 | Stall the core |
| fetch_block_o | output | 1 | Inhibit the next program-memory fetch |
| halt_o | output | 1 | Hold the core halted |
| push_req_o | output | 1 | One-cycle stack push request |
| push_ack_i | input | 1 | Push acknowledge |
| push_data_o | output | 16 | Return address to push |
| ip_load_o | output | 1 | Load the instruction pointer |
| ip_value_o | output | 16 | Value for the instruction pointer |
| status_o | output | 2 | 00 not in debug, 01 debug idle, 10 busy |

## Verification
The assertions take it that the core raises pop_ack_i only in the pop wait stage, push_ack_i only in the push wait stage, and instr_done_i no earlier than the cycle after exec_go_o. They also assume that no acknowledge arrives in the same cycle as its request. The stimulus acts like a well-behaved core. It raises each acknowledge and completion only once the matching request or run pulse has been seen, after a chosen delay of zero or more cycles, and drops it after one cycle. The only inputs it sends out of turn are the Trace strobes and debug-entry strobes that the ignore requirements call for.

// File: rtl/trace_step_pkg.sv
package trace_step_pkg;
  typedef enum logic [3:0] {
    S_OFF, S_DBG_IDLE, S_BUSY, S_POP_REQ, S_POP_WAIT, S_IGE_RST, S_RUN,
    S_EXEC, S_PUSH_REQ, S_PUSH_WAIT, S_LOAD_IP, S_CLR_IGE, S_HALT
  } step_state_e;

  localparam logic [1:0] ST_OFF  = 2'b00;
  localparam logic [1:0] ST_IDLE = 2'b01;
  localparam logic [1:0] ST_BUSY = 2'b10;

  function automatic logic [1:0] status_of(step_state_e s);
    case (s)
      S_OFF:      return ST_OFF;
      S_DBG_IDLE: return ST_IDLE;
      default:    return ST_BUSY;
    endcase
  endfunction
endpackage

// File: rtl/trace_step_fsm.sv
module trace_step_fsm
  import trace_step_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dbg_enter_i,
  input  logic        trace_i,
  input  logic        pop_ack_i,
  input  logic        push_ack_i,
  input  logic        instr_done_i,
  output step_state_e state_o
);
  step_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_OFF:       if (dbg_enter_i) state_d = S_DBG_IDLE;
      S_DBG_IDLE:  if (trace_i) state_d = S_BUSY;
      S_BUSY:      state_d = S_POP_REQ;
      S_POP_REQ:   state_d = S_POP_WAIT;
      S_POP_WAIT:  if (pop_ack_i) state_d = S_IGE_RST;
      S_IGE_RST:   state_d = S_RUN;
      S_RUN:       state_d = S_EXEC;
      S_EXEC:      if (instr_done_i) state_d = S_PUSH_REQ;
      S_PUSH_REQ:  state_d = S_PUSH_WAIT;
      S_PUSH_WAIT: if (push_ack_i) state_d = S_LOAD_IP;
      S_LOAD_IP:   state_d = S_CLR_IGE;
      S_CLR_IGE:   state_d = S_HALT;
      S_HALT:      state_d = S_DBG_IDLE;
      default:     state_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_busy_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DBG_IDLE && trace_i) |=> (state_q == S_BUSY));

  p_off_ignores_trace_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OFF && !dbg_enter_i) |=> (state_q == S_OFF));

  p_pop_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POP_WAIT && !pop_ack_i) |=> (state_q == S_POP_WAIT));

  p_exec_unbounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC && !instr_done_i) |=> (state_q == S_EXEC));

  p_push_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PUSH_WAIT && !push_ack_i) |=> (state_q == S_PUSH_WAIT));
endmodule

// File: rtl/trace_step_addr.sv
module trace_step_addr #(
  parameter int unsigned           ADDR_W = 16,
  parameter logic [ADDR_W-1:0]     VECTOR = 16'h8010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic [ADDR_W-1:0] vector_o
);
  logic [ADDR_W-1:0] ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ret_q <= '0;
    else if (cap_i) ret_q <= data_i;
  end

  assign ret_addr_o = ret_q;
  assign vector_o   = VECTOR;

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(ret_q));
endmodule

// File: rtl/trace_step_ige.sv
module trace_step_ige (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic ige_i,
  output logic saved_o
);
  logic saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    saved_q <= 1'b0;
    else if (cap_i) saved_q <= ige_i;
  end

  assign saved_o = saved_q;

  p_saved_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(saved_q));
endmodule

// File: rtl/trace_step_seq.sv
module trace_step_seq
  import trace_step_pkg::*;
#(
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VECTOR = 16'h8010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_enter_i,
  input  logic              cpu_ige_i,
  input  logic              trace_i,
  output logic              pop_req_o,
  input  logic              pop_ack_i,
  input  logic [ADDR_W-1:0] pop_data_i,
  output logic              ige_set_o,
  output logic              ige_clr_o,
  output logic              exec_go_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  input  logic              instr_done_i,
  output logic              stall_o,
  output logic              fetch_block_o,
  output logic              halt_o,
  output logic              push_req_o,
  input  logic              push_ack_i,
  output logic [ADDR_W-1:0] push_data_o,
  output logic              ip_load_o,
  output logic [ADDR_W-1:0] ip_value_o,
  output logic [1:0]        status_o
);
  step_state_e       state;
  logic              saved_ige;
  logic [ADDR_W-1:0] ret_addr;
  logic              freeze;

  trace_step_fsm u_fsm (
    .clk_i, .rst_ni, .dbg_enter_i, .trace_i, .pop_ack_i, .push_ack_i,
    .instr_done_i, .state_o(state)
  );

  trace_step_ige u_ige (
    .clk_i, .rst_ni,
    .cap_i  (state == S_OFF && dbg_enter_i),
    .ige_i  (cpu_ige_i),
    .saved_o(saved_ige)
  );

  trace_step_addr #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_addr (
    .clk_i, .rst_ni,
    .cap_i     (state == S_POP_WAIT && pop_ack_i),
    .data_i    (pop_data_i),
    .ret_addr_o(ret_addr),
    .vector_o  (ip_value_o)
  );

  // stall and fetch inhibit rise with completion, hold through halt stage
  always_comb begin
    unique case (state)
      S_PUSH_REQ, S_PUSH_WAIT, S_LOAD_IP, S_CLR_IGE, S_HALT: freeze = 1'b1;
      S_EXEC:  freeze = instr_done_i;
      default: freeze = 1'b0;
    endcase
  end

  assign pop_req_o     = (state == S_POP_REQ);
  assign ige_set_o     = (state == S_IGE_RST) && saved_ige;
  assign exec_go_o     = (state == S_RUN);
  assign exec_addr_o   = ret_addr;
  assign push_req_o    = (state == S_PUSH_REQ);
  assign push_data_o   = ret_addr;
  assign ip_load_o     = (state == S_LOAD_IP);
  assign ige_clr_o     = (state == S_CLR_IGE);
  assign stall_o       = freeze;
  assign fetch_block_o = freeze;
  assign halt_o        = (state == S_DBG_IDLE) || (state == S_BUSY) ||
                         (state == S_POP_REQ)  || (state == S_POP_WAIT) ||
                         (state == S_IGE_RST)  || (state == S_HALT);
  assign status_o      = status_of(state);

  p_one_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pop_req_o, ige_set_o, exec_go_o, push_req_o, ip_load_o, ige_clr_o}));

  p_pop_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req_o |=> !pop_req_o);

  p_push_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o |=> !push_req_o);

  p_run_after_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_go_o |-> !halt_o);

  p_load_after_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_load_o |=> ige_clr_o);

  p_clr_then_halt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ige_clr_o |=> (halt_o && stall_o && status_o == ST_BUSY));
endmodule

// File: tb/trace_step_seq_test.sv
`timescale 1ns/1ps
module trace_step_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbg_enter_i = 1'b0, cpu_ige_i = 1'b0, trace_i = 1'b0;
  logic        pop_ack_i = 1'b0, push_ack_i = 1'b0, instr_done_i = 1'b0;
  logic [15:0] pop_data_i = 16'h0;
  logic        pop_req_o, ige_set_o, ige_clr_o, exec_go_o, stall_o, fetch_block_o;
  logic        halt_o, push_req_o, ip_load_o;
  logic [15:0] exec_addr_o, push_data_o, ip_value_o;
  logic [1:0]  status_o;

  int total = 0;
  int bad = 0;
  logic [18:0] exp_q[$];
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  trace_step_seq uut (
    .clk_i(clk), .rst_ni, .dbg_enter_i, .cpu_ige_i, .trace_i,
    .pop_req_o, .pop_ack_i, .pop_data_i, .ige_set_o, .ige_clr_o,
    .exec_go_o, .exec_addr_o, .instr_done_i, .stall_o, .fetch_block_o,
    .halt_o, .push_req_o, .push_ack_i, .push_data_o, .ip_load_o,
    .ip_value_o, .status_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] strobes();
    return {pop_req_o, push_req_o, exec_go_o, ip_load_o, ige_set_o,
            ige_clr_o, stall_o, fetch_block_o, halt_o};
  endfunction

  // monitor: pops the expected strobe sequence (R12)
  always @(negedge clk) begin
    #2;
    if (rst_ni) begin
      logic [18:0] obs;
      int n;
      n = int'(pop_req_o) + int'(ige_set_o) + int'(exec_go_o) +
          int'(push_req_o) + int'(ip_load_o) + int'(ige_clr_o);
      obs = 'x;
      if (pop_req_o)  obs = {3'd1, 16'h0};
      if (ige_set_o)  obs = {3'd2, 16'h0};
      if (exec_go_o)  obs = {3'd3, exec_addr_o};
      if (push_req_o) obs = {3'd4, push_data_o};
      if (ip_load_o)  obs = {3'd5, ip_value_o};
      if (ige_clr_o)  obs = {3'd6, 16'h0};
      if (n > 1) chk(1'b0, "R12 strobe overlap", 32'(n), 32'd1);
      else if (n == 1) begin
        if (exp_q.size() == 0) chk(1'b0, "R12 unexpected strobe", 32'(obs), 32'h0);
        else begin
          logic [18:0] e;
          e = exp_q.pop_front();
          chk(obs == e, "R12 strobe order/value", 32'(obs), 32'(e));
        end
      end
    end
  end

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_trace(input logic [15:0] addr, input int pop_dly,
                          input int exec_cyc, input int push_dly,
                          input bit exp_set, input bit poke_busy);
    exp_q.push_back({3'd1, 16'h0});
    if (exp_set) exp_q.push_back({3'd2, 16'h0});
    exp_q.push_back({3'd3, addr});
    exp_q.push_back({3'd4, addr});
    exp_q.push_back({3'd5, 16'h8010});
    exp_q.push_back({3'd6, 16'h0});
    trace_i = 1'b1;
    nxt();
    trace_i = poke_busy;  // R4: strobe during busy must be ignored
    settle();
    chk(status_o == 2'b10, "R3 busy status", 32'(status_o), 32'h2);
    chk(strobes() == 9'b000000001, "R3 no action in busy cycle", 32'(strobes()), 32'h1);
    nxt();
    trace_i = 1'b0;
    settle();
    chk(pop_req_o == 1'b1, "R5 pop request", 32'(pop_req_o), 32'h1);
    nxt(); settle();
    chk(pop_req_o == 1'b0, "R5 pop pulse one cycle", 32'(pop_req_o), 32'h0);
    for (int k = 0; k < pop_dly; k++) begin
      nxt(); settle();
      chk(status_o == 2'b10 && !exec_go_o, "R5 waits for pop ack", 32'(status_o), 32'h2);
    end
    pop_ack_i = 1'b1;
    pop_data_i = addr;
    nxt();
    pop_ack_i = 1'b0;
    pop_data_i = ~addr;  // R9: later pop data must not leak into push
    settle();
    chk(ige_set_o == exp_set, "R6 enable restore", 32'(ige_set_o), 32'(exp_set));
    nxt(); settle();
    chk(exec_go_o && exec_addr_o == addr, "R7 run from popped address",
        32'(exec_addr_o), 32'(addr));
    chk(halt_o == 1'b0, "R7 halt released", 32'(halt_o), 32'h0);
    nxt(); settle();
    for (int k = 0; k < exec_cyc; k++) begin
      chk(!stall_o && !fetch_block_o && !exec_go_o, "R8 no stall before done",
          32'(stall_o), 32'h0);
      nxt(); settle();
    end
    instr_done_i = 1'b1;
    settle();
    chk(stall_o && fetch_block_o, "R8 stall on completion", 32'({stall_o, fetch_block_o}), 32'h3);
    nxt();
    instr_done_i = 1'b0;
    settle();
    chk(push_req_o && push_data_o == addr, "R9 push saved address", 32'(push_data_o), 32'(addr));
    chk(stall_o && fetch_block_o, "R8 stall held", 32'({stall_o, fetch_block_o}), 32'h3);
    nxt(); settle();
    chk(push_req_o == 1'b0, "R9 push pulse one cycle", 32'(push_req_o), 32'h0);
    for (int k = 0; k < push_dly; k++) begin
      nxt(); settle();
      chk(!ip_load_o && status_o == 2'b10, "R9 waits for push ack", 32'(ip_load_o), 32'h0);
    end
    push_ack_i = 1'b1;
    nxt();
    push_ack_i = 1'b0;
    settle();
    chk(ip_load_o && ip_value_o == 16'h8010, "R10 vector load", 32'(ip_value_o), 32'h8010);
    nxt(); settle();
    chk(ige_clr_o == 1'b1, "R11 enable clear", 32'(ige_clr_o), 32'h1);
    nxt(); settle();
    chk(halt_o && stall_o && status_o == 2'b10, "R11 halt stage",
        32'({halt_o, stall_o, status_o}), 32'hE);
    nxt(); settle();
    chk(status_o == 2'b01 && halt_o && !stall_o, "R11 back to idle",
        32'({status_o, halt_o, stall_o}), 32'h6);
  endtask

  task automatic reset_check();
    rst_ni = 1'b0;
    settle();
    chk(status_o == 2'b00 && strobes() == 9'h0, "R1 reset state",
        32'({status_o, strobes()}), 32'h0);
    nxt(); nxt();
    rst_ni = 1'b1;
    nxt(); settle();
    chk(status_o == 2'b00 && strobes() == 9'h0, "R1 after reset",
        32'({status_o, strobes()}), 32'h0);
  endtask

  task automatic enter_debug(input bit ige);
    cpu_ige_i = ige;
    dbg_enter_i = 1'b1;
    nxt();
    dbg_enter_i = 1'b0;
    cpu_ige_i = ~ige;
    settle();
    chk(status_o == 2'b01 && halt_o, "R2 debug entry", 32'({status_o, halt_o}), 32'h3);
  endtask

  initial begin
    fork
      begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    nxt();
    reset_check();
    // R4: trace while not in debug
    trace_i = 1'b1;
    nxt(); nxt();
    trace_i = 1'b0;
    settle();
    chk(status_o == 2'b00 && strobes() == 9'h0, "R4 trace ignored when off",
        32'({status_o, strobes()}), 32'h0);
    enter_debug(1'b1);
    do_trace(16'h1234, 0, 2, 1, 1'b1, 1'b0);
    do_trace(16'hFFFF, 3, 0, 0, 1'b1, 1'b1);
    // second step in a row still restores from the saved value
    reset_check();
    enter_debug(1'b0);
    // R2: re-entry strobe while in debug must not resample the enable
    cpu_ige_i = 1'b1;
    dbg_enter_i = 1'b1;
    nxt();
    dbg_enter_i = 1'b0;
    settle();
    chk(status_o == 2'b01, "R2 entry ignored in debug", 32'(status_o), 32'h1);
    do_trace(16'h0000, 1, 5, 2, 1'b0, 1'b0);
    do_trace(16'hA5C3, 0, 1, 0, 1'b0, 1'b0);
    nxt(); nxt();
    chk(exp_q.size() == 0, "R12 all strobes seen", 32'(exp_q.size()), 32'h0);
    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule